// File: doc/BRIEF.md
# Parallel-bus ADC readout sequencer

This block sits on the host side of a 14-bit successive-approximation converter that has a three-state parallel output. A request on `start` makes the sequencer drive a full conversion cycle on the converter's control lines. The first chip-select low phase, with read/convert high, opens acquisition. A second low phase, with read/convert low, starts the conversion. The sequencer then waits for the end-of-conversion flag to fall. A third low phase, with read/convert high, reads the result. While the converter is acquiring or converting, its bus floats, so the sequencer takes nothing from it in those phases. It latches the bus only after a programmable data-out delay inside the read phase.

The `BYTE_MODE` parameter selects the bus width. With a 14-bit bus the whole word is taken in a single latch. With a byte-wide bus the sequencer reads twice inside one read phase, steering the converter with the high-byte select line, and joins the two bytes into one word. Each finished word leaves with a one-cycle strobe. If the end-of-conversion flag never falls, a timeout raises a sticky error flag. From idle, the host can also ask for a reset pulse. The converter then expects its next chip-select fall to begin acquisition, so no dummy conversion is needed.

Top module: `adc_par_rdctl`

## Requirements
- R1: After synchronous reset: `adc_cs_n`=1, `adc_rc`=1, `adc_hben`=0, `adc_reset`=0, `busy`=0, `result_vld`=0, `timeout_err`=0 and `result`=0.
- R2: A start accepted in idle drives `adc_cs_n` low with `adc_rc` high for CS_LOW_CYC cycles, beginning the cycle after the accepting edge. Then `adc_cs_n` goes high with `adc_rc` low for ACQ_CYC cycles.
- R3: After acquisition, `adc_cs_n` is driven low with `adc_rc` low for CS_LOW_CYC cycles to start the conversion.
- R4: After the conversion pulse, `adc_cs_n` stays high and `adc_rc` high until a falling edge of `adc_eoc` is seen. The read phase begins the cycle after the edge that samples the fall. A fall seen in the last cycle before the timeout wins over the timeout.
- R5: In the read phase `adc_cs_n` is low and `adc_rc` is high. The bus is latched at the end of the DOUT_DLY-th cycle of that phase and at no other time. With the 14-bit bus, `result` equals `adc_d[13:0]`.
- R6: With the byte bus (BYTE_MODE=1), the low byte is read first with `adc_hben`=0. After DOUT_DLY cycles, `adc_hben` goes to 1 for another DOUT_DLY cycles. `result` = {high byte bits 5:0, low byte}, and high-byte bits 7:6 are ignored.
- R7: The cycle after the last latch, `result_vld` is high for exactly one cycle, `adc_cs_n` is high, and `result` carries the new word.
- R8: `start` and `reset_req` have no effect while `busy` is high.
- R9: If no fall of `adc_eoc` arrives within EOC_TMO cycles of waiting, the sequencer returns to idle without `result_vld`. `timeout_err` then goes to 1 and stays there until the next accepted start clears it.
- R10: `reset_req` in idle drives `adc_reset` high for RST_CYC cycles with `adc_cs_n` high, then returns to idle. The next accepted start begins acquisition.
- R11: When `start` and `reset_req` are both high in idle, the conversion sequence starts and no reset pulse is issued.
- R12: `busy` is low only in idle. In idle, `adc_cs_n` is high and `adc_reset` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | request one conversion and readout |
| reset_req | input | 1 | request a converter reset pulse |
| adc_eoc | input | 1 | end-of-conversion flag from the converter; falling edge means result ready |
| adc_d | input | BUS_W (14, or 8 when BYTE_MODE) | converter data bus |
| adc_cs_n | output | 1 | converter chip select, active low |
| adc_rc | output | 1 | read (1) / convert (0) select |
| adc_hben | output | 1 | byte select in byte mode: 0 low byte, 1 high byte |
| adc_reset | output | 1 | converter reset pulse |
| busy | output | 1 | sequence in progress |
| result | output | 14 | last captured conversion word, straight binary |
| result_vld | output | 1 | one-cycle strobe marking a new result |
| timeout_err | output | 1 | sticky end-of-conversion timeout flag |

## Verification
The bench targets the read-phase timing. A sequencer that latches one cycle early or late, or that latches during acquisition, picks up the stub's idle pattern instead of the word. It also drives the end-of-conversion fall in the very first waiting cycle and in the last one before the timeout. A wrong priority there would raise the error flag or lengthen the wait. In byte mode, the high byte carries ones in bits 7:6 and the byte order is observed on the select line, so a swapped order or an unmasked high byte shows up at once. Start and reset requests arrive while the sequencer is waiting and in the same idle cycle. A sequencer that accepted them there would restart or insert a reset pulse, and the pin trace compared every cycle would diverge.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int RES_W  = 14;
    localparam int BYTE_W = 8;
    localparam int HI_W   = RES_W - BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACQ_LO,
        ST_ACQ_HI,
        ST_CNV_LO,
        ST_WAIT,
        ST_RD_LO,
        ST_RD_HI,
        ST_DONE,
        ST_RST
    } seq_st_t;

    typedef struct packed {
        logic cs_n;
        logic rc;
        logic hben;
        logic rst_p;
        logic vld;
        logic busy;
    } pins_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Control-line values for each sequencer state.
    function automatic pins_t pins_of(input seq_st_t s);
        pins_t p;
        p = '{cs_n: 1'b1, rc: 1'b1, hben: 1'b0, rst_p: 1'b0, vld: 1'b0, busy: 1'b1};
        case (s)
            ST_IDLE:   p.busy  = 1'b0;
            ST_ACQ_LO: p.cs_n  = 1'b0;
            ST_ACQ_HI: p.rc    = 1'b0;
            ST_CNV_LO: begin
                p.cs_n = 1'b0;
                p.rc   = 1'b0;
            end
            ST_RD_LO:  p.cs_n  = 1'b0;
            ST_RD_HI:  begin
                p.cs_n = 1'b0;
                p.hben = 1'b1;
            end
            ST_DONE:   p.vld   = 1'b1;
            ST_RST:    p.rst_p = 1'b1;
            default:   p.busy  = 1'b1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    // Counts cycles spent in the current state; saturates at all ones.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter bit BYTE_MODE  = 1'b0,
    parameter int CS_LOW_CYC = 2,
    parameter int ACQ_CYC    = 4,
    parameter int DOUT_DLY   = 3,
    parameter int EOC_TMO    = 256,
    parameter int RST_CYC    = 2,
    parameter int CW         = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          reset_req,
    input  logic          adc_eoc,
    input  logic [CW-1:0] cnt,
    output logic          st_chg,
    output logic          lat_lo,
    output logic          lat_hi,
    output logic          err,
    output pins_t         pins
);

    localparam logic [CW-1:0] L_CS  = CW'(CS_LOW_CYC - 1);
    localparam logic [CW-1:0] L_ACQ = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] L_DO  = CW'(DOUT_DLY - 1);
    localparam logic [CW-1:0] L_TMO = CW'(EOC_TMO - 1);
    localparam logic [CW-1:0] L_RST = CW'(RST_CYC - 1);

    seq_st_t st, nxt;
    logic    eoc_q;
    logic    eoc_fall;
    logic    tmo_hit;

    assign eoc_fall = eoc_q && !adc_eoc;

    always_comb begin
        nxt     = st;
        lat_lo  = 1'b0;
        lat_hi  = 1'b0;
        tmo_hit = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start)          nxt = ST_ACQ_LO;
                else if (reset_req) nxt = ST_RST;
            end
            ST_ACQ_LO: if (cnt == L_CS)  nxt = ST_ACQ_HI;
            ST_ACQ_HI: if (cnt == L_ACQ) nxt = ST_CNV_LO;
            ST_CNV_LO: if (cnt == L_CS)  nxt = ST_WAIT;
            ST_WAIT: begin
                if (eoc_fall) begin
                    nxt = ST_RD_LO;
                end else if (cnt == L_TMO) begin
                    nxt     = ST_IDLE;
                    tmo_hit = 1'b1;
                end
            end
            ST_RD_LO: begin
                if (cnt == L_DO) begin
                    lat_lo = 1'b1;
                    nxt    = BYTE_MODE ? ST_RD_HI : ST_DONE;
                end
            end
            ST_RD_HI: begin
                if (cnt == L_DO) begin
                    lat_hi = 1'b1;
                    nxt    = ST_DONE;
                end
            end
            ST_DONE:  nxt = ST_IDLE;
            ST_RST:   if (cnt == L_RST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign st_chg = (nxt != st);
    assign pins   = pins_of(st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            eoc_q <= 1'b0;
            err   <= 1'b0;
        end else begin
            st    <= nxt;
            eoc_q <= adc_eoc;
            if (st == ST_IDLE && start) begin
                err <= 1'b0;
            end else if (tmo_hit) begin
                err <= 1'b1;
            end
        end
    end

    // R4
    eoc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD_LO && $past(st) == ST_WAIT) |-> $past(!adc_eoc));

    // R9
    tmo_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(st) == ST_WAIT && st == ST_IDLE));

    // R8
    acq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACQ_LO) |-> ($past(st) == ST_IDLE || $past(st) == ST_ACQ_LO));

endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble
    import adc_rd_pkg::*;
#(
    parameter bit BYTE_MODE = 1'b0,
    parameter int BUS_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_lo,
    input  logic             lat_hi,
    input  logic [BUS_W-1:0] bus,
    output logic [RES_W-1:0] result
);

    generate
        if (BYTE_MODE) begin : g_byte
            logic [BYTE_W-1:0] lo_q;
            logic              unused_top;

            // Bits above the result width in the high byte carry nothing.
            assign unused_top = ^bus[BUS_W-1:HI_W];

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q   <= '0;
                    result <= '0;
                end else begin
                    if (lat_lo) lo_q   <= bus[BYTE_W-1:0];
                    if (lat_hi) result <= {bus[HI_W-1:0], lo_q};
                end
            end
        end else begin : g_word
            logic unused_hi;

            assign unused_hi = lat_hi;

            always_ff @(posedge clk) begin
                if (rst) begin
                    result <= '0;
                end else if (lat_lo) begin
                    result <= bus[RES_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/adc_par_rdctl.sv
module adc_par_rdctl
    import adc_rd_pkg::*;
#(
    parameter bit  BYTE_MODE  = 1'b0,
    parameter int  CS_LOW_CYC = 2,
    parameter int  ACQ_CYC    = 4,
    parameter int  DOUT_DLY   = 3,
    parameter int  EOC_TMO    = 256,
    parameter int  RST_CYC    = 2,
    localparam int BUS_W      = BYTE_MODE ? BYTE_W : RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             reset_req,
    input  logic             adc_eoc,
    input  logic [BUS_W-1:0] adc_d,
    output logic             adc_cs_n,
    output logic             adc_rc,
    output logic             adc_hben,
    output logic             adc_reset,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             result_vld,
    output logic             timeout_err
);

    localparam int MAXC = max_of(max_of(max_of(CS_LOW_CYC, ACQ_CYC), max_of(DOUT_DLY, EOC_TMO)), RST_CYC);
    localparam int CW   = $clog2(MAXC + 1) + 1;

    logic [CW-1:0] cnt;
    logic          st_chg;
    logic          lat_lo;
    logic          lat_hi;
    pins_t         pins;

    adc_rd_timer #(.CW(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .cnt (cnt)
    );

    adc_rd_fsm #(
        .BYTE_MODE  (BYTE_MODE),
        .CS_LOW_CYC (CS_LOW_CYC),
        .ACQ_CYC    (ACQ_CYC),
        .DOUT_DLY   (DOUT_DLY),
        .EOC_TMO    (EOC_TMO),
        .RST_CYC    (RST_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .reset_req (reset_req),
        .adc_eoc   (adc_eoc),
        .cnt       (cnt),
        .st_chg    (st_chg),
        .lat_lo    (lat_lo),
        .lat_hi    (lat_hi),
        .err       (timeout_err),
        .pins      (pins)
    );

    adc_rd_assemble #(.BYTE_MODE(BYTE_MODE), .BUS_W(BUS_W)) u_asm (
        .clk    (clk),
        .rst    (rst),
        .lat_lo (lat_lo),
        .lat_hi (lat_hi),
        .bus    (adc_d),
        .result (result)
    );

    assign adc_cs_n   = pins.cs_n;
    assign adc_rc     = pins.rc;
    assign adc_hben   = pins.hben;
    assign adc_reset  = pins.rst_p;
    assign busy       = pins.busy;
    assign result_vld = pins.vld;

    // R5
    lat_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (lat_lo || lat_hi) |-> (!adc_cs_n && adc_rc));

    // R6
    lat_hi_chk: assert property (@(posedge clk) disable iff (rst)
        lat_hi |-> adc_hben);

    // R7
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_vld |=> !result_vld);

    // R10
    rst_cs_chk: assert property (@(posedge clk) disable iff (rst)
        adc_reset |-> adc_cs_n);

    // R12
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (adc_cs_n && !adc_reset));

endmodule

// File: tb/adc_par_rdctl_tb.sv
module adc_par_rdctl_tb;

    localparam int CSL  = 2;
    localparam int ACQ  = 3;
    localparam int DLY  = 2;
    localparam int TMO  = 20;
    localparam int RSTC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [1:0] start_s = '0;
    logic [1:0] rreq_s  = '0;
    logic [1:0] eoc_s   = 2'b11;
    logic [13:0] val_w = '0;
    logic [13:0] val_b = '0;

    logic cs_w, rc_w, hb_w, ar_w, busy_w, vld_w, err_w;
    logic cs_b, rc_b, hb_b, ar_b, busy_b, vld_b, err_b;
    logic [13:0] res_w, res_b;
    logic [13:0] d_w;
    logic [7:0]  d_b;

    // Behavioural converter stubs: count chip-select falls, drive data on the third.
    int   fc_w = 0, fc_b = 0;
    logic arm_w = 1'b0, arm_b = 1'b0;

    always @(negedge cs_w or posedge ar_w) begin
        if (ar_w) begin
            fc_w  <= 0;
            arm_w <= 1'b0;
        end else begin
            arm_w <= (fc_w == 2) && rc_w;
            fc_w  <= (fc_w == 2) ? 0 : fc_w + 1;
        end
    end

    always @(negedge cs_b or posedge ar_b) begin
        if (ar_b) begin
            fc_b  <= 0;
            arm_b <= 1'b0;
        end else begin
            arm_b <= (fc_b == 2) && rc_b;
            fc_b  <= (fc_b == 2) ? 0 : fc_b + 1;
        end
    end

    assign d_w = (arm_w && !cs_w) ? val_w : (val_w ^ 14'h1555);
    assign d_b = (arm_b && !cs_b) ? (hb_b ? {2'b11, val_b[13:8]} : val_b[7:0]) : 8'h5A;

    adc_par_rdctl #(
        .BYTE_MODE(1'b0), .CS_LOW_CYC(CSL), .ACQ_CYC(ACQ),
        .DOUT_DLY(DLY), .EOC_TMO(TMO), .RST_CYC(RSTC)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start_s[0]), .reset_req(rreq_s[0]),
        .adc_eoc(eoc_s[0]), .adc_d(d_w), .adc_cs_n(cs_w), .adc_rc(rc_w),
        .adc_hben(hb_w), .adc_reset(ar_w), .busy(busy_w), .result(res_w),
        .result_vld(vld_w), .timeout_err(err_w)
    );

    adc_par_rdctl #(
        .BYTE_MODE(1'b1), .CS_LOW_CYC(CSL), .ACQ_CYC(ACQ),
        .DOUT_DLY(DLY), .EOC_TMO(TMO), .RST_CYC(RSTC)
    ) u_dut_b (
        .clk(clk), .rst(rst), .start(start_s[1]), .reset_req(rreq_s[1]),
        .adc_eoc(eoc_s[1]), .adc_d(d_b), .adc_cs_n(cs_b), .adc_rc(rc_b),
        .adc_hben(hb_b), .adc_reset(ar_b), .busy(busy_b), .result(res_b),
        .result_vld(vld_b), .timeout_err(err_b)
    );

    int checks = 0;
    int errors = 0;

    // Expected pin vector per cycle: {err, busy, vld, reset, hben, rc, cs_n}.
    function automatic logic [6:0] ev(input logic cs, input logic rc, input logic hb,
                                      input logic ar, input logic vld, input logic bsy,
                                      input logic er);
        return {er, bsy, vld, ar, hb, rc, cs};
    endfunction

    logic [6:0]  qw[$], qb[$];
    string       tgw[$], tgb[$];
    logic [13:0] rw[$], rb[$];
    logic        xerr_w = 1'b0, xerr_b = 1'b0;
    logic        lerr_w = 1'b0, lerr_b = 1'b0;
    logic        chk_on = 1'b0;

    task automatic cmp_vec(input string who, input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s pins {err,busy,vld,rst,hben,rc,cs_n}: actual %b expected %b at %0t",
                     tag, who, got, exp, $time);
        end
    endtask

    task automatic cmp_res(input string who, input string tag, input logic [13:0] got, input logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s result: actual %h expected %h at %0t", tag, who, got, exp, $time);
        end
    endtask

    logic [6:0] e_w, e_b;
    string      t_w, t_b;

    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            if (qw.size() > 0) begin
                e_w = qw.pop_front();
                t_w = tgw.pop_front();
                lerr_w = e_w[6];
            end else begin
                e_w = ev(1, 1, 0, 0, 0, 0, lerr_w);
                t_w = "R12";
            end
            cmp_vec("word", t_w, {err_w, busy_w, vld_w, ar_w, hb_w, rc_w, cs_w}, e_w);
            if (e_w[4]) cmp_res("word", "R5", res_w, rw.pop_front());

            if (qb.size() > 0) begin
                e_b = qb.pop_front();
                t_b = tgb.pop_front();
                lerr_b = e_b[6];
            end else begin
                e_b = ev(1, 1, 0, 0, 0, 0, lerr_b);
                t_b = "R12";
            end
            cmp_vec("byte", t_b, {err_b, busy_b, vld_b, ar_b, hb_b, rc_b, cs_b}, e_b);
            if (e_b[4]) cmp_res("byte", "R6", res_b, rb.pop_front());
        end
    end

    task automatic push(input bit b, input logic [6:0] e, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            if (b) begin
                qb.push_back(e);
                tgb.push_back(t);
            end else begin
                qw.push_back(e);
                tgw.push_back(t);
            end
        end
    endtask

    function automatic int qlen(input bit b);
        return b ? qb.size() : qw.size();
    endfunction

    // One conversion: w = extra waiting cycles before the end-of-conversion fall.
    task automatic run_conv(input bit b, input logic [13:0] val, input int w,
                            input bit poke, input bit both, input bit tmo);
        int n;
        @(negedge clk);
        push(b, ev(0, 1, 0, 0, 0, 1, 0), both ? "R11" : "R2", CSL);
        push(b, ev(1, 0, 0, 0, 0, 1, 0), "R2", ACQ);
        push(b, ev(0, 0, 0, 0, 0, 1, 0), "R3", CSL);
        if (tmo) begin
            push(b, ev(1, 1, 0, 0, 0, 1, 0), poke ? "R8" : "R9", TMO);
            push(b, ev(1, 1, 0, 0, 0, 0, 1), "R9", 1);
            if (b) xerr_b = 1'b1; else xerr_w = 1'b1;
        end else begin
            push(b, ev(1, 1, 0, 0, 0, 1, 0), poke ? "R8" : "R4", w + 1);
            push(b, ev(0, 1, 0, 0, 0, 1, 0), b ? "R6" : "R5", DLY);
            if (b) push(b, ev(0, 1, 1, 0, 0, 1, 0), "R6", DLY);
            push(b, ev(1, 1, 0, 0, 1, 1, 0), "R7", 1);
            if (b) rb.push_back(val); else rw.push_back(val);
            if (b) xerr_b = 1'b0; else xerr_w = 1'b0;
        end
        if (b) val_b = val; else val_w = val;
        eoc_s[b]   = 1'b1;
        start_s[b] = 1'b1;
        if (both) rreq_s[b] = 1'b1;
        n = tmo ? 2 * CSL + ACQ + 3 : 2 * CSL + ACQ + w + 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) begin
                start_s[b] = 1'b0;
                rreq_s[b]  = 1'b0;
            end
            if (poke && i == 2 * CSL + ACQ) begin
                start_s[b] = 1'b1;
                rreq_s[b]  = 1'b1;
            end
            if (poke && i == 2 * CSL + ACQ + 1) begin
                start_s[b] = 1'b0;
                rreq_s[b]  = 1'b0;
            end
        end
        if (!tmo) eoc_s[b] = 1'b0;
        while (qlen(b) != 0) @(negedge clk);
    endtask

    task automatic run_reset(input bit b);
        @(negedge clk);
        push(b, ev(1, 1, 0, 1, 0, 1, b ? xerr_b : xerr_w), "R10", RSTC);
        rreq_s[b] = 1'b1;
        @(negedge clk);
        rreq_s[b] = 1'b0;
        while (qlen(b) != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state on both instances
        cmp_vec("word", "R1", {err_w, busy_w, vld_w, ar_w, hb_w, rc_w, cs_w}, ev(1, 1, 0, 0, 0, 0, 0));
        cmp_res("word", "R1", res_w, 14'h0);
        cmp_vec("byte", "R1", {err_b, busy_b, vld_b, ar_b, hb_b, rc_b, cs_b}, ev(1, 1, 0, 0, 0, 0, 0));
        cmp_res("byte", "R1", res_b, 14'h0);
        chk_on = 1'b1;

        // 14-bit bus
        run_conv(0, 14'h3FFF, 0, 0, 0, 0);        // R4 fall in first waiting cycle, R5
        run_conv(0, 14'h0000, 3, 0, 0, 0);        // R5 all zeros
        run_conv(0, 14'h2A5C, TMO - 1, 0, 0, 0);  // R4 fall in last cycle before timeout
        run_conv(0, 14'h1B37, 4, 1, 0, 0);        // R8 start/reset during wait ignored
        run_conv(0, 14'h0000, 0, 0, 0, 1);        // R9 timeout
        run_reset(0);                             // R10 reset pulse, err kept
        run_conv(0, 14'h0C3A, 1, 0, 1, 0);        // R11 priority, R9 err cleared, R10 realigned

        // byte bus
        run_conv(1, 14'h1234, 0, 0, 0, 0);        // R6
        run_conv(1, 14'h3FC1, 5, 1, 0, 0);        // R6 high bits, R8
        run_conv(1, 14'h0000, 0, 0, 0, 1);        // R9
        run_reset(1);                             // R10
        run_conv(1, 14'h2D0F, 2, 0, 1, 0);        // R11, R6

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule